// File: doc/BRIEF.md
# USB Host Subsystem Configuration Register Block

This block holds the configuration and identification registers of a USB host subsystem. It answers on three separate memory windows, each with its own select input. The first is a 4 KB window for the transceiver-link layer. The second is a 1 KB window for host-level configuration. The third is a 1 KB window of EHCI extension registers. Every window accepts only full 32-bit accesses. The registers hold revision codes, fixed status words, configuration and debug fields, and a ULPI control field. Each writable register keeps only the bits allowed by its own write mask. The host controllers, the ULPI bus and the interrupt sources sit outside the block, and both interrupt outputs stay low.

A write to the host configuration register with bit 1 set acts as a soft reset. The host-window and link-window registers go back to their reset values in the same cycle, and that overrides the value being written. The ULPI field in the EHCI window keeps its value through this reset. Accesses of the wrong width return an error flag. So do writes to read-only registers and accesses to unmapped offsets in the host and link windows. The read data and the error flag are registered and appear one cycle after the access.

Top module: `usbh_cfg_regs`

## Requirements
- R1: Host window offset 0x000 reads 0x10 and offset 0x014 reads 0x7. Both are read-only, and no write changes what they return.
- R2: Host offset 0x010 (system configuration) resets to 0x1 and stores a written value ANDed with 0x311D.
- R3: A word write to host offset 0x010 whose data has bit 1 set returns the registers at host 0x010, 0x040, 0x044 and link 0x010 to their reset values (0x1, 0x700, 0x20, 0x1). The written data is not stored.
- R4: Host offset 0x040 resets to 0x700 with write mask 0x1F3D. Host offset 0x044 resets to 0x20 with write mask 0xF00FF.
- R5: In the EHCI window, offset 0x0A4 resets to 0 and keeps only bits 31:28 of a write. Every other offset in that window reads 0, and a write there has no effect and raises no error.
- R6: The soft reset of R3 does not change EHCI offset 0x0A4.
- R7: In the link window, offsets 0x000 and 0x014 read 0x1, and offsets 0x018 and 0x01C read 0. All four are read-only. Link offset 0x010 resets to 0x1 and stores a written value ANDed with 0xFFFFFEE0.
- R8: The size input encodes 0 = byte, 1 = halfword, 2 = word and 3 = reserved. In any window, an access whose size is not word raises the error flag, returns read data 0 and changes no register.
- R9: In the host and link windows, a write to a read-only offset, or any access to an offset with no register, raises the error flag, returns 0 and changes no register.
- R10: Read data and the error flag are registered and appear in the cycle after the access. Both are 0 in a cycle that follows no access or a successful write. The error flag is high for exactly one cycle per failing access. At most one select is high in any cycle.
- R11: The two interrupt outputs are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_link | input | 1 | Access to the link window this cycle |
| sel_host | input | 1 | Access to the host window this cycle |
| sel_ext | input | 1 | Access to the EHCI extension window this cycle |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte offset inside the selected window (the 1 KB windows use bits 9:0) |
| size | input | 2 | Access width code (see R8) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | Registered one-cycle error flag |
| irq_host | output | 1 | Host controller interrupt, held low |
| irq_link | output | 1 | Link layer interrupt, held low |

## Verification
The assertions check the following on every cycle:
- only one window select is high;
- error responses carry zero data;
- both interrupt lines stay low;
- the host status word and the link revision read back their fixed values;
- an access of the wrong width leaves host state untouched;
- a soft reset puts the host and link registers back to their reset values while the ULPI field keeps its value.

Only the bench's scenarios can show the rest:
- that each write mask keeps exactly the right bits;
- that the unmapped EHCI offsets swallow writes silently;
- that a register still holds its earlier value after rejected accesses.

The bench shows these by comparing every response against a behavioural model of the register contents.

// File: rtl/usbh_cfg_pkg.sv
package usbh_cfg_pkg;

    localparam int DATA_W      = 32;
    localparam int LINK_OFF_W  = 12;
    localparam int SMALL_OFF_W = 10;

    // access width codes
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // host window layout
    localparam logic [11:0] HOST_REV_OFF  = 12'h000;
    localparam logic [11:0] HOST_SYS_OFF  = 12'h010;
    localparam logic [11:0] HOST_STAT_OFF = 12'h014;
    localparam logic [11:0] HOST_CFG_OFF  = 12'h040;
    localparam logic [11:0] HOST_DBG_OFF  = 12'h044;

    localparam logic [31:0] HOST_REV_VAL  = 32'h0000_0010;
    localparam logic [31:0] HOST_STAT_VAL = 32'h0000_0007;
    localparam logic [31:0] HOST_SYS_MSK  = 32'h0000_311D;
    localparam logic [31:0] HOST_CFG_MSK  = 32'h0000_1F3D;
    localparam logic [31:0] HOST_DBG_MSK  = 32'h000F_00FF;
    localparam int          SOFT_RST_BIT  = 1;

    // link window layout
    localparam logic [11:0] LINK_REV_OFF  = 12'h000;
    localparam logic [11:0] LINK_SYS_OFF  = 12'h010;
    localparam logic [11:0] LINK_STAT_OFF = 12'h014;
    localparam logic [11:0] LINK_IST_OFF  = 12'h018;
    localparam logic [11:0] LINK_IEN_OFF  = 12'h01C;

    localparam logic [31:0] LINK_REV_VAL  = 32'h0000_0001;
    localparam logic [31:0] LINK_STAT_VAL = 32'h0000_0001;
    localparam logic [31:0] LINK_SYS_MSK  = 32'hFFFF_FEE0;
    localparam logic [31:0] LINK_SYS_RST  = 32'h0000_0001;

    // extension window layout
    localparam logic [11:0] EXT_ULPI_OFF  = 12'h0A4;
    localparam logic [31:0] EXT_ULPI_MSK  = 32'hF000_0000;

    typedef struct packed {
        logic [DATA_W-1:0] sys;
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] dbg;
    } host_regs_t;

    localparam host_regs_t HOST_RST = '{
        sys: 32'h0000_0001,
        cfg: 32'h0000_0700,
        dbg: 32'h0000_0020
    };

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } resp_t;

endpackage

// File: rtl/usbh_host_win.sv
module usbh_host_win
    import usbh_cfg_pkg::*;
#(
    parameter int OFF_W = SMALL_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic              word_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [DATA_W-1:0] wdata_i,
    output resp_t             resp_o,
    output logic              soft_rst_o
);

    host_regs_t regs_d, regs_q;

    always_comb begin
        regs_d       = regs_q;
        resp_o       = '0;
        soft_rst_o   = 1'b0;
        if (sel_i) begin
            if (!word_i) begin
                resp_o.err = 1'b1;
            end else if (off_i == OFF_W'(HOST_REV_OFF)) begin
                if (wr_i) resp_o.err = 1'b1;
                else      resp_o.rdata = HOST_REV_VAL;
            end else if (off_i == OFF_W'(HOST_STAT_OFF)) begin
                if (wr_i) resp_o.err = 1'b1;
                else      resp_o.rdata = HOST_STAT_VAL;
            end else if (off_i == OFF_W'(HOST_SYS_OFF)) begin
                if (wr_i) begin
                    regs_d.sys = wdata_i & HOST_SYS_MSK;
                    if (wdata_i[SOFT_RST_BIT]) begin
                        regs_d     = HOST_RST;
                        soft_rst_o = 1'b1;
                    end
                end else begin
                    resp_o.rdata = regs_q.sys;
                end
            end else if (off_i == OFF_W'(HOST_CFG_OFF)) begin
                if (wr_i) regs_d.cfg = wdata_i & HOST_CFG_MSK;
                else      resp_o.rdata = regs_q.cfg;
            end else if (off_i == OFF_W'(HOST_DBG_OFF)) begin
                if (wr_i) regs_d.dbg = wdata_i & HOST_DBG_MSK;
                else      resp_o.rdata = regs_q.dbg;
            end else begin
                resp_o.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= HOST_RST;
        else        regs_q <= regs_d;
    end

    assert_softrst_vals_R3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> (regs_q == HOST_RST));

    assert_badwidth_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !word_i) |=> $stable(regs_q));

endmodule

// File: rtl/usbh_link_win.sv
module usbh_link_win
    import usbh_cfg_pkg::*;
#(
    parameter int OFF_W = LINK_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic              word_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              soft_rst_i,
    output resp_t             resp_o
);

    logic [DATA_W-1:0] sys_d, sys_q;

    always_comb begin
        sys_d  = sys_q;
        resp_o = '0;
        if (soft_rst_i) begin
            sys_d = LINK_SYS_RST;
        end
        if (sel_i) begin
            if (!word_i) begin
                resp_o.err = 1'b1;
            end else if (off_i == OFF_W'(LINK_REV_OFF)) begin
                if (wr_i) resp_o.err = 1'b1;
                else      resp_o.rdata = LINK_REV_VAL;
            end else if (off_i == OFF_W'(LINK_STAT_OFF)) begin
                if (wr_i) resp_o.err = 1'b1;
                else      resp_o.rdata = LINK_STAT_VAL;
            end else if (off_i == OFF_W'(LINK_IST_OFF) ||
                         off_i == OFF_W'(LINK_IEN_OFF)) begin
                if (wr_i) resp_o.err = 1'b1;
                else      resp_o.rdata = '0;
            end else if (off_i == OFF_W'(LINK_SYS_OFF)) begin
                if (wr_i) sys_d = wdata_i & LINK_SYS_MSK;
                else      resp_o.rdata = sys_q;
            end else begin
                resp_o.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sys_q <= LINK_SYS_RST;
        else        sys_q <= sys_d;
    end

    assert_link_softrst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_i && !sel_i) |=> (sys_q == LINK_SYS_RST));

    assert_link_badwidth_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !word_i && !soft_rst_i) |=> $stable(sys_q));

endmodule

// File: rtl/usbh_ext_win.sv
module usbh_ext_win
    import usbh_cfg_pkg::*;
#(
    parameter int OFF_W = SMALL_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic              word_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              soft_rst_i,
    output resp_t             resp_o
);

    logic [DATA_W-1:0] ulpi_d, ulpi_q;

    always_comb begin
        ulpi_d = ulpi_q;
        resp_o = '0;
        if (sel_i) begin
            if (!word_i) begin
                resp_o.err = 1'b1;
            end else if (off_i == OFF_W'(EXT_ULPI_OFF)) begin
                if (wr_i) ulpi_d = wdata_i & EXT_ULPI_MSK;
                else      resp_o.rdata = ulpi_q;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ulpi_q <= '0;
        else        ulpi_q <= ulpi_d;
    end

    assert_ext_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_i && !sel_i) |=> $stable(ulpi_q));

    assert_ext_badwidth_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !word_i) |=> $stable(ulpi_q));

endmodule

// File: rtl/usbh_cfg_regs.sv
module usbh_cfg_regs
    import usbh_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_link,
    input  logic        sel_host,
    input  logic        sel_ext,
    input  logic        wr_en,
    input  logic [11:0] addr,
    input  logic [1:0]  size,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        err,
    output logic        irq_host,
    output logic        irq_link
);

    logic  word_acc;
    logic  soft_rst;
    resp_t host_resp, link_resp, ext_resp;
    resp_t resp_d, resp_q;

    assign word_acc = (size == SZ_WORD);

    usbh_host_win #(.OFF_W(SMALL_OFF_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel_host),
        .wr_i       (wr_en),
        .word_i     (word_acc),
        .off_i      (addr[SMALL_OFF_W-1:0]),
        .wdata_i    (wdata),
        .resp_o     (host_resp),
        .soft_rst_o (soft_rst)
    );

    usbh_link_win #(.OFF_W(LINK_OFF_W)) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel_link),
        .wr_i       (wr_en),
        .word_i     (word_acc),
        .off_i      (addr[LINK_OFF_W-1:0]),
        .wdata_i    (wdata),
        .soft_rst_i (soft_rst),
        .resp_o     (link_resp)
    );

    usbh_ext_win #(.OFF_W(SMALL_OFF_W)) u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel_ext),
        .wr_i       (wr_en),
        .word_i     (word_acc),
        .off_i      (addr[SMALL_OFF_W-1:0]),
        .wdata_i    (wdata),
        .soft_rst_i (soft_rst),
        .resp_o     (ext_resp)
    );

    // windows return zero when unselected, so their responses merge by OR
    always_comb begin
        resp_d = host_resp | link_resp | ext_resp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign rdata    = resp_q.rdata;
    assign err      = resp_q.err;
    assign irq_host = 1'b0;
    assign irq_link = 1'b0;

    assert_one_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_link, sel_host, sel_ext}));

    assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rdata == '0));

    assert_irq_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_host || irq_link));

    assert_host_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_host && !wr_en && word_acc && addr[SMALL_OFF_W-1:0] == 10'h014)
        |=> (rdata == 32'h7 && !err));

    assert_link_rev_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_link && !wr_en && word_acc && addr == 12'h000)
        |=> (rdata == 32'h1 && !err));

endmodule

// File: tb/usbh_cfg_regs_tb.sv
`timescale 1ns/1ps
module usbh_cfg_regs_tb_top;

    localparam int WIN_LINK = 0;
    localparam int WIN_HOST = 1;
    localparam int WIN_EXT  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_link = 1'b0, sel_host = 1'b0, sel_ext = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [1:0]  size = 2'd2;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err, irq_host, irq_link;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural model state
    logic [31:0] m_hsys, m_hcfg, m_hdbg, m_lsys, m_ulpi;

    always #10 clk = ~clk;

    usbh_cfg_regs dut_i (
        .clk(clk), .rst_n(rst_n),
        .sel_link(sel_link), .sel_host(sel_host), .sel_ext(sel_ext),
        .wr_en(wr_en), .addr(addr), .size(size), .wdata(wdata),
        .rdata(rdata), .err(err), .irq_host(irq_host), .irq_link(irq_link)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    task automatic model_reset();
        m_hsys = 32'h1; m_hcfg = 32'h700; m_hdbg = 32'h20;
        m_lsys = 32'h1; m_ulpi = 32'h0;
    endtask

    // one access; response compared one cycle later
    task automatic acc(input string req, input int win, input bit wr,
                       input int off, input int sz, input logic [31:0] d);
        logic [31:0] e_rd = '0;
        bit          e_er = 1'b0;
        if (sz != 2) begin
            e_er = 1'b1;
        end else if (win == WIN_HOST) begin
            case (off)
                'h000: if (wr) e_er = 1; else e_rd = 32'h10;
                'h014: if (wr) e_er = 1; else e_rd = 32'h7;
                'h010: if (wr) begin
                           if (d[1]) begin
                               m_hsys = 32'h1; m_hcfg = 32'h700;
                               m_hdbg = 32'h20; m_lsys = 32'h1;
                           end else m_hsys = d & 32'h311D;
                       end else e_rd = m_hsys;
                'h040: if (wr) m_hcfg = d & 32'h1F3D; else e_rd = m_hcfg;
                'h044: if (wr) m_hdbg = d & 32'hF00FF; else e_rd = m_hdbg;
                default: e_er = 1;
            endcase
        end else if (win == WIN_LINK) begin
            case (off)
                'h000, 'h014: if (wr) e_er = 1; else e_rd = 32'h1;
                'h018, 'h01C: if (wr) e_er = 1; else e_rd = 32'h0;
                'h010: if (wr) m_lsys = d & 32'hFFFFFEE0; else e_rd = m_lsys;
                default: e_er = 1;
            endcase
        end else begin
            if (off == 'h0A4) begin
                if (wr) m_ulpi = d & 32'hF0000000; else e_rd = m_ulpi;
            end
        end
        @(negedge clk);
        sel_link = (win == WIN_LINK);
        sel_host = (win == WIN_HOST);
        sel_ext  = (win == WIN_EXT);
        wr_en = wr; addr = 12'(off); size = 2'(sz); wdata = d;
        @(negedge clk);
        sel_link = 0; sel_host = 0; sel_ext = 0; wr_en = 0;
        chk(req, $sformatf("rdata win%0d off 0x%03h", win, off), rdata, e_rd);
        chk(req, $sformatf("err win%0d off 0x%03h", win, off), {31'b0, err}, {31'b0, e_er});
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        chk(req, "idle rdata", rdata, 32'h0);
        chk(req, "idle err", {31'b0, err}, 32'h0);
        chk("R11", "irq lines", {30'b0, irq_host, irq_link}, 32'h0);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R10");

        // R1 fixed host values
        acc("R1", WIN_HOST, 0, 'h000, 2, 0);
        acc("R1", WIN_HOST, 0, 'h014, 2, 0);
        // R2 system config reset and mask
        acc("R2", WIN_HOST, 0, 'h010, 2, 0);
        acc("R2", WIN_HOST, 1, 'h010, 2, 32'hFFFF_FFFD);
        acc("R2", WIN_HOST, 0, 'h010, 2, 0);
        // R4 host config and debug
        acc("R4", WIN_HOST, 0, 'h040, 2, 0);
        acc("R4", WIN_HOST, 0, 'h044, 2, 0);
        acc("R4", WIN_HOST, 1, 'h040, 2, 32'hFFFF_FFFF);
        acc("R4", WIN_HOST, 1, 'h044, 2, 32'hFFFF_FFFF);
        acc("R4", WIN_HOST, 0, 'h040, 2, 0);
        acc("R4", WIN_HOST, 0, 'h044, 2, 0);
        acc("R4", WIN_HOST, 1, 'h040, 2, 32'h0000_0A5A);
        acc("R4", WIN_HOST, 0, 'h040, 2, 0);
        // R7 link window
        acc("R7", WIN_LINK, 0, 'h000, 2, 0);
        acc("R7", WIN_LINK, 0, 'h014, 2, 0);
        acc("R7", WIN_LINK, 0, 'h018, 2, 0);
        acc("R7", WIN_LINK, 0, 'h01C, 2, 0);
        acc("R7", WIN_LINK, 0, 'h010, 2, 0);
        acc("R7", WIN_LINK, 1, 'h010, 2, 32'hFFFF_FFFF);
        acc("R7", WIN_LINK, 0, 'h010, 2, 0);
        // R5 extension window
        acc("R5", WIN_EXT, 0, 'h0A4, 2, 0);
        acc("R5", WIN_EXT, 1, 'h0A4, 2, 32'hFFFF_FFFF);
        acc("R5", WIN_EXT, 0, 'h0A4, 2, 0);
        acc("R5", WIN_EXT, 1, 'h050, 2, 32'h1234_5678);
        acc("R5", WIN_EXT, 0, 'h050, 2, 0);
        acc("R5", WIN_EXT, 0, 'h000, 2, 0);
        // R3 / R6 soft reset overrides the written value
        acc("R3", WIN_HOST, 1, 'h010, 2, 32'hFFFF_FFFF);
        acc("R3", WIN_HOST, 0, 'h010, 2, 0);
        acc("R3", WIN_HOST, 0, 'h040, 2, 0);
        acc("R3", WIN_HOST, 0, 'h044, 2, 0);
        acc("R3", WIN_LINK, 0, 'h010, 2, 0);
        acc("R6", WIN_EXT, 0, 'h0A4, 2, 0);
        // R8 bad widths
        acc("R8", WIN_HOST, 1, 'h040, 0, 32'h0);
        acc("R8", WIN_HOST, 0, 'h040, 2, 0);
        acc("R8", WIN_LINK, 0, 'h000, 1, 0);
        acc("R8", WIN_LINK, 1, 'h010, 3, 32'hFFFF_FFFF);
        acc("R8", WIN_LINK, 0, 'h010, 2, 0);
        acc("R8", WIN_EXT, 1, 'h0A4, 0, 32'h0);
        acc("R8", WIN_EXT, 0, 'h0A4, 2, 0);
        acc("R8", WIN_HOST, 1, 'h010, 1, 32'h0000_0002);
        acc("R8", WIN_HOST, 0, 'h044, 2, 0);
        // R9 read-only and unmapped offsets
        acc("R9", WIN_HOST, 1, 'h000, 2, 32'hFFFF_FFFF);
        acc("R9", WIN_HOST, 1, 'h014, 2, 32'h0);
        acc("R9", WIN_HOST, 0, 'h000, 2, 0);
        acc("R9", WIN_HOST, 0, 'h020, 2, 0);
        acc("R9", WIN_HOST, 1, 'h048, 2, 32'hFFFF_FFFF);
        acc("R9", WIN_LINK, 1, 'h018, 2, 32'hFFFF_FFFF);
        acc("R9", WIN_LINK, 0, 'h018, 2, 0);
        acc("R9", WIN_LINK, 0, 'h100, 2, 0);
        acc("R9", WIN_LINK, 1, 'h000, 2, 32'h5);
        // R10 error lasts one cycle, writes give zero data
        acc("R10", WIN_HOST, 0, 'h030, 2, 0);
        idle("R10");
        acc("R10", WIN_HOST, 1, 'h044, 2, 32'h0001_0003);
        idle("R10");
        acc("R10", WIN_HOST, 0, 'h044, 2, 0);
        idle("R11");

        done = 1'b1;
        report();
    end

endmodule